// File: doc/BRIEF.md
# Watchdog Timer with Interrupt Clear

A memory-mapped watchdog that counts a 16-bit value down at a programmable tick rate. The tick comes from an 8-bit prescaler followed by a power-of-two divider. When the count has reached zero and the next tick arrives, the block latches a pending interrupt and can pulse a system reset request. It then reloads the count from a reload register. Software keeps the system alive by rewriting the live count before it runs out.

Counting needs two things at once: the run bit in the control register and an external counter-enable input. Software acknowledges a pending interrupt by writing any value to a dedicated write-only clear register. A debug-mask bit lets a debug-acknowledge input silence both outputs while a debugger holds the system. The register bus is a simple select/write strobe with combinational read data. Registers are addressed by word index: 0 is control, 1 is reload, 2 is live count and 3 is interrupt clear.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x8003, the reload and count registers read 0x8000, and `irq_o` and `rst_req_o` are low. The control register layout is bit0 run, bit1 reset enable, bit2 interrupt enable, bit3 debug mask, bits[5:4] divider code and bits[15:8] prescaler.
- R2: While counting, the count drops by exactly one every (prescaler+1) × 2^(4+divider code) clock cycles.
- R3: The count holds its value unless the run bit and `cnt_enable_i` are both high, or software writes the count.
- R4: A tick that finds the count at zero sets the pending flag and reloads the count from the reload register.
- R5: At each expiry `rst_req_o` pulses for exactly one cycle, but only when the reset-enable bit is set.
- R6: `irq_o` is high exactly when the pending flag is set and the interrupt-enable bit is set. The pending flag survives a change of the enable.
- R7: A write of any value to word 3 clears the pending flag. A read of word 3 returns zero and leaves the flag unchanged.
- R8: With the debug-mask bit set and `dbg_ack_i` high, `irq_o` and `rst_req_o` stay low while expiry still sets the pending flag. With the debug-mask bit clear, `dbg_ack_i` has no effect.
- R9: Writing zero to the control register stops counting and drives both outputs low.
- R10: The count, reload and control registers read back the value last written, and a count write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is in progress |
| cnt_enable_i | input | 1 | External counter enable |
| dbg_ack_i | input | 1 | Debug acknowledge |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Properties checked on every cycle:
- The reset pulse is one cycle wide and only follows an enabled cycle.
- The outputs are silent under an active debug mask.
- `irq_o` is never high without both the pending flag and the interrupt enable.
- The count is frozen while counting is gated.
- An expiry loads the reload value.
- A clear write drops the pending flag.
- Reads of word 3 return zero.

The tick period, the fact that the pending flag survives masking and enable changes, and stop-on-zero-control can only be shown by the bench's timed scenarios, which observe the ports over hundreds of cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // register word indices on the bus
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_IRQCLR = 2'd3
   } wdog_reg_e;

   // control register bit positions
   localparam int unsigned BIT_RUN   = 0;
   localparam int unsigned BIT_RSTEN = 1;
   localparam int unsigned BIT_IRQEN = 2;
   localparam int unsigned BIT_DBGM  = 3;
   localparam int unsigned DIV_LSB   = 4;
   localparam int unsigned PRE_LSB   = 8;

   // single-bit controls decoded from the control register
   typedef struct packed {
      logic dbg_mask;
      logic irq_en;
      logic rst_en;
      logic run;
   } wdog_flags_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PRE_W     = 8,
   parameter int unsigned DIV_SEL_W = 2,
   parameter int unsigned CNT_INIT  = 32'h8000,
   parameter int unsigned PRE_INIT  = 32'h80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [CNT_W-1:0]     count_q,
   output wdog_flags_t          flags,
   output logic [DIV_SEL_W-1:0] div_sel,
   output logic [PRE_W-1:0]     presc,
   output logic [CNT_W-1:0]     reload_q,
   output logic                 cnt_wr,
   output logic [CNT_W-1:0]     cnt_wdata,
   output logic                 irq_clr
);

   localparam int unsigned CTL_TOP = PRE_LSB + PRE_W;

   if (CTL_TOP > DATA_W) begin : g_bad_pre
      $error("wdog_regs: prescaler field does not fit the data width");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdog_regs: count width exceeds the data width");
   end
   if (DIV_LSB + DIV_SEL_W > PRE_LSB) begin : g_bad_div
      $error("wdog_regs: divider field overlaps the prescaler field");
   end

   wdog_reg_e reg_sel;
   logic      wr_any;
   logic      rd_any;

   assign reg_sel = wdog_reg_e'(bus_addr);
   assign wr_any  = bus_sel && bus_wr;
   assign rd_any  = bus_sel && !bus_wr;

   assign cnt_wr    = wr_any && (reg_sel == REG_COUNT);
   assign cnt_wdata = bus_wdata[CNT_W-1:0];
   assign irq_clr   = wr_any && (reg_sel == REG_IRQCLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags.run      <= 1'b1;
         flags.rst_en   <= 1'b1;
         flags.irq_en   <= 1'b0;
         flags.dbg_mask <= 1'b0;
         div_sel        <= '0;
         presc          <= PRE_W'(PRE_INIT);
         reload_q       <= CNT_W'(CNT_INIT);
      end else if (wr_any) begin
         if (reg_sel == REG_CTRL) begin
            flags.run      <= bus_wdata[BIT_RUN];
            flags.rst_en   <= bus_wdata[BIT_RSTEN];
            flags.irq_en   <= bus_wdata[BIT_IRQEN];
            flags.dbg_mask <= bus_wdata[BIT_DBGM];
            div_sel        <= bus_wdata[DIV_LSB +: DIV_SEL_W];
            presc          <= bus_wdata[PRE_LSB +: PRE_W];
         end
         if (reg_sel == REG_RELOAD) begin
            reload_q <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   // read mux; the clear register always reads as zero
   always_comb begin
      bus_rdata = '0;
      if (rd_any) begin
         case (reg_sel)
            REG_CTRL: begin
               bus_rdata[BIT_RUN]               = flags.run;
               bus_rdata[BIT_RSTEN]             = flags.rst_en;
               bus_rdata[BIT_IRQEN]             = flags.irq_en;
               bus_rdata[BIT_DBGM]              = flags.dbg_mask;
               bus_rdata[DIV_LSB +: DIV_SEL_W]  = div_sel;
               bus_rdata[PRE_LSB +: PRE_W]      = presc;
            end
            REG_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            REG_COUNT:  bus_rdata[CNT_W-1:0] = count_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
   parameter int unsigned PRE_W         = 8,
   parameter int unsigned DIV_SEL_W     = 2,
   parameter int unsigned DIV_BASE_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 cnt_en,
   input  logic [PRE_W-1:0]     presc,
   input  logic [DIV_SEL_W-1:0] div_sel,
   output logic                 tick_o
);

   localparam int unsigned DIV_CODES    = 1 << DIV_SEL_W;
   localparam int unsigned DIV_MAX_LOG2 = DIV_BASE_LOG2 + DIV_CODES - 1;

   if (DIV_BASE_LOG2 < 1) begin : g_bad_base
      $error("wdog_tick: divider base must be at least two");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("wdog_tick: prescaler width must be at least one");
   end

   localparam logic [DIV_SEL_W-1:0] SEL_TOP = '1;
   localparam logic [DIV_MAX_LOG2-1:0] ALL_ONES = '1;

   logic [PRE_W-1:0]        pre_cnt;
   logic [DIV_MAX_LOG2-1:0] div_cnt;
   logic [DIV_MAX_LOG2-1:0] div_mask;
   logic [DIV_SEL_W-1:0]    mask_shift;
   logic                    active;
   logic                    pre_hit;

   // divider code c keeps the lowest DIV_BASE_LOG2+c bits of the mask
   assign mask_shift = SEL_TOP - div_sel;
   assign div_mask   = ALL_ONES >> mask_shift;

   assign active  = run && cnt_en;
   assign pre_hit = (pre_cnt >= presc);
   assign tick_o  = active && pre_hit && ((div_cnt & div_mask) == div_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (cnt_en) begin
         if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned CNT_INIT     = 32'h8000,
   parameter bit          HAS_DBG_MASK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  wdog_flags_t      flags,
   input  logic [CNT_W-1:0] reload_q,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             irq_clr,
   input  logic             dbg_ack_i,
   output logic [CNT_W-1:0] count_q,
   output logic             pending_q,
   output logic             expire,
   output logic             irq_o,
   output logic             rst_req_o
);

   logic rst_pulse_q;
   logic quiet;

   assign expire = tick && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q     <= CNT_W'(CNT_INIT);
         pending_q   <= 1'b0;
         rst_pulse_q <= 1'b0;
      end else begin
         if (cnt_wr) begin
            count_q <= cnt_wdata;
         end else if (tick) begin
            count_q <= expire ? reload_q : count_q - 1'b1;
         end
         // a new expiry wins over a clear in the same cycle
         if (expire) begin
            pending_q <= 1'b1;
         end else if (irq_clr) begin
            pending_q <= 1'b0;
         end
         rst_pulse_q <= expire && flags.rst_en;
      end
   end

   if (HAS_DBG_MASK) begin : g_dbg
      assign quiet = flags.dbg_mask && dbg_ack_i;
   end else begin : g_nodbg
      logic unused_dbg;
      assign unused_dbg = flags.dbg_mask ^ dbg_ack_i;
      assign quiet      = 1'b0;
   end

   assign irq_o     = pending_q && flags.irq_en && !quiet;
   assign rst_req_o = rst_pulse_q && !quiet;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned PRE_W         = 8,
   parameter int unsigned DIV_SEL_W     = 2,
   parameter int unsigned DIV_BASE_LOG2 = 4,
   parameter int unsigned CNT_INIT      = 32'h8000,
   parameter int unsigned PRE_INIT      = 32'h80,
   parameter bit          HAS_DBG_MASK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cnt_enable_i,
   input  logic              dbg_ack_i,
   output logic              irq_o,
   output logic              rst_req_o
);

   wdog_flags_t          flags;
   logic [DIV_SEL_W-1:0] div_sel;
   logic [PRE_W-1:0]     presc;
   logic [CNT_W-1:0]     reload_q;
   logic [CNT_W-1:0]     count_q;
   logic                 cnt_wr;
   logic [CNT_W-1:0]     cnt_wdata;
   logic                 irq_clr;
   logic                 tick;
   logic                 pending_q;
   logic                 expire;

   wdog_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_SEL_W(DIV_SEL_W),
      .CNT_INIT(CNT_INIT), .PRE_INIT(PRE_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_q(count_q), .flags(flags), .div_sel(div_sel), .presc(presc),
      .reload_q(reload_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .irq_clr(irq_clr)
   );

   wdog_tick #(
      .PRE_W(PRE_W), .DIV_SEL_W(DIV_SEL_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(flags.run), .cnt_en(cnt_enable_i),
      .presc(presc), .div_sel(div_sel), .tick_o(tick)
   );

   wdog_core #(
      .CNT_W(CNT_W), .CNT_INIT(CNT_INIT), .HAS_DBG_MASK(HAS_DBG_MASK)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .flags(flags),
      .reload_q(reload_q), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .irq_clr(irq_clr), .dbg_ack_i(dbg_ack_i), .count_q(count_q),
      .pending_q(pending_q), .expire(expire), .irq_o(irq_o),
      .rst_req_o(rst_req_o)
   );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cnt_enable_i,
   input logic              dbg_ack_i,
   input logic              irq_o,
   input logic              rst_req_o,
   input wdog_flags_t       flags,
   input logic              pending_q,
   input logic              expire,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  reload_q
);

   logic cnt_wr_c;
   logic clr_wr_c;
   logic clr_rd_c;

   assign cnt_wr_c = bus_sel && bus_wr && (bus_addr == 2'd2);
   assign clr_wr_c = bus_sel && bus_wr && (bus_addr == 2'd3);
   assign clr_rd_c = bus_sel && !bus_wr && (bus_addr == 2'd3);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(flags.run && cnt_enable_i) && !cnt_wr_c) |=> $stable(count_q));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pending_q) && !$past(cnt_wr_c)) |-> (count_q == $past(reload_q)));

   p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   p_pulse_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(flags.rst_en));

   p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pending_q && flags.irq_en));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_c && !expire) |=> !pending_q);

   p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rd_c |-> (bus_rdata == '0));

   p_dbg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.dbg_mask && dbg_ack_i) |-> (!irq_o && !rst_req_o));

endmodule

bind wdog_timer wdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cnt_enable_i(cnt_enable_i),
   .dbg_ack_i(dbg_ack_i), .irq_o(irq_o), .rst_req_o(rst_req_o),
   .flags(flags), .pending_q(pending_q), .expire(expire),
   .count_q(count_q), .reload_q(reload_q)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cnt_enable_i = 1'b0;
   logic        dbg_ack_i = 1'b0;
   logic        irq_o;
   logic        rst_req_o;

   always #5 clk = ~clk;

   wdog_timer i_wdog_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_enable_i(cnt_enable_i), .dbg_ack_i(dbg_ack_i),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   typedef struct {
      string       req;
      logic [31:0] act;
      logic [31:0] exp;
   } item_t;

   item_t sb_q[$];
   int    n_vec = 0;
   int    n_err = 0;
   int    rst_pulses = 0;
   int    run_len = 0;
   int    max_len = 0;
   bit    done = 0;

   // driver side: queue an observed value with its expectation
   task automatic push(input string req, input logic [31:0] act, input logic [31:0] exp);
      item_t it;
      it.req = req; it.act = act; it.exp = exp;
      sb_q.push_back(it);
   endtask

   // monitor side: compare queued items and watch the reset output
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_vec++;
         if (it.act !== it.exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", it.req, it.act, it.exp);
         end
      end
      if (rst_n && rst_req_o) begin
         rst_pulses++;
         run_len++;
         if (run_len > max_len) max_len = run_len;
      end else begin
         run_len = 0;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_irq(input int limit, output bit seen);
      seen = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (irq_o) begin
            seen = 1;
            break;
         end
      end
   endtask

   task automatic finish_run();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] c0;
      logic [31:0] c1;
      int          cyc;
      int          p0;
      bit          seen;
      bit          hi;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      push("R1 irq", {31'd0, irq_o}, 32'd0);
      push("R1 rst", {31'd0, rst_req_o}, 32'd0);
      bus_read(2'd0, rd); push("R1 ctrl", rd, 32'h0000_8003);
      bus_read(2'd1, rd); push("R1 reload", rd, 32'h0000_8000);
      bus_read(2'd2, rd); push("R1 count", rd, 32'h0000_8000);

      // R3 external enable low freezes the count
      bus_write(2'd0, 32'h0000_0007);
      bus_write(2'd2, 32'd5);
      repeat (100) @(negedge clk);
      bus_read(2'd2, rd); push("R3 hold", rd, 32'd5);

      // R2 period with prescaler 2, divider code 1: 3*32 = 96 cycles
      bus_write(2'd0, 32'h0000_0211);
      bus_write(2'd1, 32'd100);
      bus_write(2'd2, 32'd100);
      cnt_enable_i = 1'b1;
      bus_read(2'd2, c0);
      for (int i = 0; i < 400; i++) begin
         bus_read(2'd2, rd);
         if (rd != c0) break;
      end
      c0 = rd;
      cyc = 0;
      for (int i = 0; i < 400; i++) begin
         bus_read(2'd2, c1);
         cyc++;
         if (c1 != c0) break;
      end
      push("R2 period", cyc, 32'd96);
      push("R2 step", c1, c0 - 32'd1);

      // R4/R5 expiry with reset enabled
      bus_write(2'd0, 32'h0000_0007);
      bus_write(2'd1, 32'd7);
      bus_write(2'd2, 32'd2);
      p0 = rst_pulses;
      max_len = 0;
      wait_irq(300, seen);
      cnt_enable_i = 1'b0;
      push("R6 irq on expiry", {31'd0, seen}, 32'd1);
      bus_read(2'd2, rd); push("R4 reload", rd, 32'd7);
      repeat (3) @(negedge clk);
      push("R5 pulse count", rst_pulses - p0, 32'd1);
      push("R5 pulse width", max_len, 32'd1);

      // R7 read of clear register returns zero, leaves flag; write clears
      bus_read(2'd3, rd); push("R7 read zero", rd, 32'd0);
      @(negedge clk);
      push("R7 read no effect", {31'd0, irq_o}, 32'd1);
      bus_write(2'd3, 32'hFFFF_FFFF);
      push("R7 clear", {31'd0, irq_o}, 32'd0);

      // R5 no pulse without reset enable; R6 enable gating
      bus_write(2'd0, 32'h0000_0005);
      bus_write(2'd2, 32'd1);
      p0 = rst_pulses;
      cnt_enable_i = 1'b1;
      wait_irq(300, seen);
      cnt_enable_i = 1'b0;
      push("R4 pending set", {31'd0, seen}, 32'd1);
      repeat (3) @(negedge clk);
      push("R5 no pulse", rst_pulses - p0, 32'd0);
      bus_write(2'd0, 32'h0000_0001);
      push("R6 irq masked by enable", {31'd0, irq_o}, 32'd0);
      bus_write(2'd0, 32'h0000_0005);
      push("R6 pending kept", {31'd0, irq_o}, 32'd1);
      bus_write(2'd3, 32'd0);

      // R8 debug mask silences outputs, pending still set
      bus_write(2'd0, 32'h0000_000F);
      bus_write(2'd2, 32'd0);
      dbg_ack_i = 1'b1;
      p0 = rst_pulses;
      hi = 0;
      cnt_enable_i = 1'b1;
      repeat (40) begin
         @(negedge clk);
         if (irq_o) hi = 1;
      end
      cnt_enable_i = 1'b0;
      push("R8 irq silent", {31'd0, hi}, 32'd0);
      push("R8 reset silent", rst_pulses - p0, 32'd0);
      dbg_ack_i = 1'b0;
      @(negedge clk);
      push("R8 pending under mask", {31'd0, irq_o}, 32'd1);
      bus_write(2'd0, 32'h0000_0007);
      dbg_ack_i = 1'b1;
      @(negedge clk);
      push("R8 no mask no effect", {31'd0, irq_o}, 32'd1);
      dbg_ack_i = 1'b0;

      // R9 zero control stops everything
      bus_write(2'd0, 32'h0000_0000);
      push("R9 irq off", {31'd0, irq_o}, 32'd0);
      p0 = rst_pulses;
      cnt_enable_i = 1'b1;
      bus_read(2'd2, c0);
      repeat (300) @(negedge clk);
      bus_read(2'd2, rd); push("R9 stopped", rd, c0);
      push("R9 no reset", rst_pulses - p0, 32'd0);
      cnt_enable_i = 1'b0;
      bus_write(2'd3, 32'd1);

      // R10 read-back
      bus_write(2'd2, 32'h0000_1234);
      bus_read(2'd2, rd); push("R10 count", rd, 32'h0000_1234);
      bus_write(2'd1, 32'h0000_BEEF);
      bus_read(2'd1, rd); push("R10 reload", rd, 32'h0000_BEEF);
      bus_write(2'd0, 32'h0000_0F3F);
      bus_read(2'd0, rd); push("R10 ctrl", rd, 32'h0000_0F3F);

      done = 1;
      finish_run();
   end

endmodule